// File: doc/BRIEF.md
# Three-Channel Interval Timer

This block holds three independent 16-bit down-counters. A host programs them through four byte-wide addresses: addresses 0, 1 and 2 are the data ports of channels 0, 1 and 2, and address 3 takes commands. A command either programs one channel (which bytes it uses, and its counting mode), takes a snapshot of one channel's count, or takes snapshots of count and status on several channels at once. Each channel drives one output level, `out`, and has one `gate` enable input.

Counting advances only on `tick`, a single-cycle strobe that stands for the slow timer input clock of about 1.19 MHz. Three behaviours can be selected: a one-shot that raises its output at terminal count, a free-running square wave that reloads itself, and a one-time strobe that pulses low for a single tick. A count that has been written takes effect on the next tick, not on the write. A channel can be moved from the square wave to the one-shot while it runs, by issuing a new programming command.

Top module: `ivl_timer`

## Requirements
- R1: Synchronous reset clears `out` and `rdata` to 0, sets every channel to low-then-high byte access in one-shot mode with a count of 0, and stops all counting.
- R2: A programming command at address 3 has bits 7:6 = channel (00/01/10), bits 5:4 = access (01 low only, 10 high only, 11 low then high) and bits 3:1 = mode (000 one-shot, 011 square wave, 100 strobe). The next cycle, that channel's `out` is high for square wave and strobe and low for any other mode code. The channel then stops counting until a complete count has been written. This applies even when the channel was running.
- R3: With low-then-high access, two writes to a data port load the low byte and then the high byte. Two reads return the low byte and then the high byte. `rdata` is registered: it shows the byte of a read in the cycle after `rd_en`, reads at address 3 return 0, and `rdata` holds its value when no read is made.
- R4: A completed count is moved into the counter on the next `tick`, whatever the gate level. That tick does not decrement. In one-shot mode with count N, `out` rises after tick N+1, counting from the loading tick.
- R5: In one-shot mode `out` stays high after terminal count, and the counter keeps decrementing and wraps from 0 to 0xFFFF.
- R6: In square-wave mode with count N, `out` repeats with a period of N ticks, reloading by itself. It is high for ceil(N/2) ticks, starting with the loading tick, and low for floor(N/2) ticks.
- R7: In strobe mode `out` stays high, goes low for exactly one tick when the count reaches 0 for the first time, and then returns high.
- R8: While a channel's `gate` is low, ticks do not change its count or its `out`. `out` changes only on a tick or a programming command.
- R9: A count of 0 stands for 65536. In one-shot mode, `out` rises after tick 65537, counting from the loading tick.
- R10: A latch command (bits 5:4 = 00) freezes the channel's count. Reads return that frozen value while counting continues. A second latch issued before the frozen value has been fully read is ignored. Once the value has been read, reads show the live count again.
- R11: A read-back command has bits 7:6 = 11. Bit 5 = 0 latches counts and bit 4 = 0 latches status, on every channel whose select bit is set (bit 1 for channel 0, bit 2 for channel 1, bit 3 for channel 2). A latched status byte is returned by the first read, ahead of any latched count. The status byte is {out, null-count, access[1:0], mode[2:0], 0}.
- R12: The null-count flag is set by a programming command and by a completed count write, and it is cleared when the count is loaded.
- R13: With low-only access, a write sets the count to {0x00, byte} and every read returns the low byte. With high-only access, a write sets the count to {byte, 0x00} and every read returns the high byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Byte write strobe |
| rd_en | input | 1 | Byte read strobe |
| addr | input | 2 | 0..2 channel data port, 3 command port |
| wdata | input | 8 | Write byte |
| tick | input | 1 | Single-cycle count-enable strobe (timer input clock) |
| gate | input | 3 | Per-channel counting enable |
| rdata | output | 8 | Registered read byte |
| out | output | 3 | Per-channel output level |

## Verification
The assertions assume that `wr_en` and `rd_en` are never high in the same cycle. They also assume that commands and data writes arrive as separate single-cycle strobes, and that no count write completes in the same cycle as a `tick`. The bench keeps to these assumptions by driving every bus operation on the falling edge as a one-cycle pulse. It issues ticks only between bus operations and never during them. The bench then checks `out` and the bytes it reads back against arithmetic from the count and the number of ticks applied.

// File: rtl/ivl_timer_pkg.sv
package ivl_timer_pkg;
  localparam int CH_NUM = 3;
  localparam int BYTE_W = 8;
  localparam int CNT_W  = 2 * BYTE_W;
  localparam int ADDR_W = 2;

  localparam logic [2:0] MD_ONESHOT = 3'b000;
  localparam logic [2:0] MD_SQUARE  = 3'b011;
  localparam logic [2:0] MD_STROBE  = 3'b100;

  localparam logic [1:0] ACC_LATCH = 2'b00;
  localparam logic [1:0] ACC_LO    = 2'b01;
  localparam logic [1:0] ACC_HI    = 2'b10;
  localparam logic [1:0] ACC_LOHI  = 2'b11;
endpackage

// File: rtl/ivl_timer_cmd.sv
module ivl_timer_cmd
  import ivl_timer_pkg::*;
(
  input  logic              cmd_wr,
  input  logic [7:1]        cmd,
  output logic [CH_NUM-1:0] cw_wr,
  output logic [CH_NUM-1:0] latch_cnt,
  output logic [CH_NUM-1:0] latch_st
);
  logic rb;
  assign rb = (cmd[7:6] == 2'b11);

  for (genvar i = 0; i < CH_NUM; i++) begin : g_dec
    logic hit;
    assign hit          = cmd_wr && !rb && (cmd[7:6] == i[1:0]);
    assign cw_wr[i]     = hit && (cmd[5:4] != ACC_LATCH);
    assign latch_cnt[i] = (hit && (cmd[5:4] == ACC_LATCH)) ||
                          (cmd_wr && rb && !cmd[5] && cmd[i+1]);
    assign latch_st[i]  = cmd_wr && rb && !cmd[4] && cmd[i+1];
  end
endmodule

// File: rtl/ivl_timer_chan.sv
module ivl_timer_chan
  import ivl_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              tick,
  input  logic              gate,
  input  logic              cw_wr,
  input  logic [5:1]        cw,
  input  logic              latch_cnt,
  input  logic              latch_st,
  input  logic              data_wr,
  input  logic              data_rd,
  input  logic [BYTE_W-1:0] wdata,
  output logic [BYTE_W-1:0] rd_byte,
  output logic              out
);
  logic [1:0]        acc_q;
  logic [2:0]        mode_q;
  logic [CNT_W-1:0]  cr_q, ce_q, ol_q, ce_dec, src;
  logic [BYTE_W-1:0] st_q;
  logic cnt_lat_q, st_lat_q, wptr_q, rptr_q, pend_q, run_q, null_q, out_q, shot_q;
  logic wr_done, do_load, is_sq, is_strobe, new_lvl;
  logic [CNT_W:0] n_ext, nxt_ext;

  assign is_sq     = (mode_q == MD_SQUARE);
  assign is_strobe = (mode_q == MD_STROBE);
  assign new_lvl   = (cw[3:1] == MD_SQUARE) || (cw[3:1] == MD_STROBE);
  assign n_ext     = (cr_q == '0) ? {1'b1, {CNT_W{1'b0}}} : {1'b0, cr_q};
  assign ce_dec    = ce_q - 1'b1;
  assign nxt_ext   = (ce_q == 1) ? n_ext : {1'b0, ce_dec};
  assign wr_done   = data_wr && (acc_q != ACC_LOHI || wptr_q);
  assign do_load   = tick && pend_q && !wr_done;
  assign src       = cnt_lat_q ? ol_q : ce_q;

  always_comb begin
    if (st_lat_q)                              rd_byte = st_q;
    else if (acc_q == ACC_HI)                  rd_byte = src[CNT_W-1:BYTE_W];
    else if (acc_q == ACC_LOHI && rptr_q)      rd_byte = src[CNT_W-1:BYTE_W];
    else                                       rd_byte = src[BYTE_W-1:0];
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      acc_q <= ACC_LOHI; mode_q <= MD_ONESHOT;
      cr_q <= '0; ce_q <= '0; ol_q <= '0; st_q <= '0;
      cnt_lat_q <= 1'b0; st_lat_q <= 1'b0; wptr_q <= 1'b0; rptr_q <= 1'b0;
      pend_q <= 1'b0; run_q <= 1'b0; null_q <= 1'b0; out_q <= 1'b0; shot_q <= 1'b0;
    end else if (cw_wr) begin
      acc_q <= cw[5:4]; mode_q <= cw[3:1];
      wptr_q <= 1'b0; rptr_q <= 1'b0; pend_q <= 1'b0; run_q <= 1'b0;
      null_q <= 1'b1; out_q <= new_lvl; shot_q <= 1'b0;
      cnt_lat_q <= 1'b0; st_lat_q <= 1'b0;
    end else begin
      if (latch_cnt && !cnt_lat_q) begin
        ol_q <= ce_q; cnt_lat_q <= 1'b1;
      end
      if (latch_st && !st_lat_q) begin
        st_q <= {out_q, null_q, acc_q, mode_q, 1'b0}; st_lat_q <= 1'b1;
      end
      if (data_wr) begin
        case (acc_q)
          ACC_LO: cr_q <= {{BYTE_W{1'b0}}, wdata};
          ACC_HI: cr_q <= {wdata, {BYTE_W{1'b0}}};
          default: begin
            if (wptr_q) cr_q[CNT_W-1:BYTE_W] <= wdata;
            else        cr_q[BYTE_W-1:0]     <= wdata;
            wptr_q <= !wptr_q;
          end
        endcase
        if (wr_done) begin
          pend_q <= 1'b1; null_q <= 1'b1;
        end
      end
      if (data_rd) begin
        if (st_lat_q) st_lat_q <= 1'b0;
        else if (acc_q == ACC_LOHI) begin
          rptr_q <= !rptr_q;
          if (rptr_q) cnt_lat_q <= 1'b0;
        end else cnt_lat_q <= 1'b0;
      end
      if (do_load) begin
        ce_q <= cr_q; pend_q <= 1'b0; null_q <= 1'b0; run_q <= 1'b1;
        shot_q <= 1'b0; out_q <= is_sq || is_strobe;
      end else if (tick && run_q && gate) begin
        if (is_sq) begin
          ce_q  <= nxt_ext[CNT_W-1:0];
          out_q <= nxt_ext > {1'b0, n_ext[CNT_W:1]};
        end else if (is_strobe) begin
          ce_q  <= ce_dec;
          out_q <= !(ce_q == 1 && !shot_q);
          if (ce_q == 1) shot_q <= 1'b1;
        end else begin
          ce_q <= ce_dec;
          if (ce_q == 1) out_q <= 1'b1;
        end
      end
    end
  end

  assign out = out_q;
endmodule

// File: rtl/ivl_timer.sv
module ivl_timer
  import ivl_timer_pkg::*;
(
  input  logic              clk,
  input  logic              rst,
  input  logic              wr_en,
  input  logic              rd_en,
  input  logic [ADDR_W-1:0] addr,
  input  logic [BYTE_W-1:0] wdata,
  input  logic              tick,
  input  logic [CH_NUM-1:0] gate,
  output logic [BYTE_W-1:0] rdata,
  output logic [CH_NUM-1:0] out
);
  localparam logic [ADDR_W-1:0] CMD_ADDR = ADDR_W'(CH_NUM);

  logic [CH_NUM-1:0] cw_wr, latch_cnt, latch_st;
  logic [BYTE_W-1:0] rd_bytes [CH_NUM];
  logic [BYTE_W-1:0] rd_sel;
  logic [BYTE_W-1:0] rdata_q;

  ivl_timer_cmd u_cmd (
    .cmd_wr    (wr_en && addr == CMD_ADDR),
    .cmd       (wdata[7:1]),
    .cw_wr     (cw_wr),
    .latch_cnt (latch_cnt),
    .latch_st  (latch_st)
  );

  for (genvar i = 0; i < CH_NUM; i++) begin : g_ch
    ivl_timer_chan u_ch (
      .clk       (clk),
      .rst       (rst),
      .tick      (tick),
      .gate      (gate[i]),
      .cw_wr     (cw_wr[i]),
      .cw        (wdata[5:1]),
      .latch_cnt (latch_cnt[i]),
      .latch_st  (latch_st[i]),
      .data_wr   (wr_en && addr == ADDR_W'(i)),
      .data_rd   (rd_en && addr == ADDR_W'(i)),
      .wdata     (wdata),
      .rd_byte   (rd_bytes[i]),
      .out       (out[i])
    );
  end

  always_comb begin
    rd_sel = '0;
    for (int i = 0; i < CH_NUM; i++)
      if (addr == ADDR_W'(i)) rd_sel = rd_bytes[i];
  end

  always_ff @(posedge clk) begin
    if (rst)        rdata_q <= '0;
    else if (rd_en) rdata_q <= rd_sel;
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/ivl_timer_chk.sv
module ivl_timer_chk (
  input logic       clk,
  input logic       rst,
  input logic       wr_en,
  input logic       rd_en,
  input logic [1:0] addr,
  input logic [7:0] wdata,
  input logic       tick,
  input logic [7:0] rdata,
  input logic [2:0] out
);
  p_reset_r1: assert property (@(posedge clk) rst |=> (out == 3'b000 && rdata == 8'h00));

  p_cw_level_r2: assert property (@(posedge clk) disable iff (rst)
    (wr_en && addr == 2'd3 && wdata[7:6] == 2'b00 && wdata[5:4] != 2'b00)
    |=> out[0] == ($past(wdata[3:1]) == 3'b011 || $past(wdata[3:1]) == 3'b100));

  p_out_quiet_r8: assert property (@(posedge clk) disable iff (rst)
    (!tick && !(wr_en && addr == 2'd3)) |=> $stable(out));

  p_rdata_hold_r3: assert property (@(posedge clk) disable iff (rst)
    !rd_en |=> $stable(rdata));

  p_cmd_read_r3: assert property (@(posedge clk) disable iff (rst)
    (rd_en && addr == 2'd3) |=> rdata == 8'h00);
endmodule

bind ivl_timer ivl_timer_chk u_chk (
  .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
  .wdata(wdata), .tick(tick), .rdata(rdata), .out(out)
);

// File: tb/ivl_timer_test.sv
module ivl_timer_test;
  logic       clk = 1'b0;
  logic       rst = 1'b1;
  logic       wr_en = 1'b0, rd_en = 1'b0, tick = 1'b0;
  logic [1:0] addr = 2'd0;
  logic [7:0] wdata = 8'h00;
  logic [2:0] gate = 3'b111;
  logic [7:0] rdata;
  logic [2:0] out;
  int total = 0, bad = 0;

  ivl_timer uut (
    .clk(clk), .rst(rst), .wr_en(wr_en), .rd_en(rd_en), .addr(addr),
    .wdata(wdata), .tick(tick), .gate(gate), .rdata(rdata), .out(out)
  );

  always #10 clk = ~clk;

  task automatic chk(input string tag, input int act, input int exp);
    total++;
    if (act != exp) begin
      bad++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [1:0] a, input logic [7:0] d);
    @(negedge clk); wr_en = 1'b1; addr = a; wdata = d;
    @(negedge clk); wr_en = 1'b0;
  endtask

  task automatic rd(input logic [1:0] a, output logic [7:0] v);
    @(negedge clk); rd_en = 1'b1; addr = a;
    @(negedge clk); rd_en = 1'b0; v = rdata;
  endtask

  task automatic tickn(input int n);
    @(negedge clk); tick = 1'b1;
    repeat (n) @(negedge clk);
    tick = 1'b0;
  endtask

  initial begin
    logic [7:0] v;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    // R1 reset state
    chk("R1 out", out, 0);
    chk("R1 rdata", rdata, 0);
    rd(2'd0, v); chk("R1 count lo", v, 0);
    rd(2'd0, v); chk("R1 count hi", v, 0);
    rd(2'd3, v); chk("R3 cmd port reads 0", v, 0);

    // R2, R3, R4, R5, R11, R12: one-shot on channel 0
    wr(2'd3, 8'h30); chk("R2 oneshot low", out[0], 0);
    wr(2'd0, 8'h05); wr(2'd0, 8'h00);
    wr(2'd3, 8'hE2); rd(2'd0, v); chk("R12 status null set", v, 8'h70);
    tickn(1);
    wr(2'd3, 8'hE2); rd(2'd0, v); chk("R12 status null clear", v, 8'h30);
    rd(2'd0, v); chk("R3 read lo", v, 8'h05);
    rd(2'd0, v); chk("R3 read hi", v, 8'h00);
    tickn(4); chk("R4 out before terminal", out[0], 0);
    tickn(1); chk("R4 out at terminal", out[0], 1);
    tickn(3); chk("R5 out stays high", out[0], 1);
    rd(2'd0, v); chk("R5 wrap lo", v, 8'hFD);
    rd(2'd0, v); chk("R5 wrap hi", v, 8'hFF);

    // R10 latch on channel 1
    wr(2'd3, 8'h70); wr(2'd1, 8'h34); wr(2'd1, 8'h12);
    tickn(1); tickn(16);
    wr(2'd3, 8'h40); tickn(5); wr(2'd3, 8'h40);
    rd(2'd1, v); chk("R10 frozen lo", v, 8'h24);
    rd(2'd1, v); chk("R10 frozen hi", v, 8'h12);
    rd(2'd1, v); chk("R10 live lo", v, 8'h1F);
    rd(2'd1, v); chk("R10 live hi", v, 8'h12);

    // R13 single-byte access on channel 2
    wr(2'd3, 8'h90); wr(2'd2, 8'h07); tickn(1);
    rd(2'd2, v); chk("R13 lo only", v, 8'h07);
    rd(2'd2, v); chk("R13 lo only again", v, 8'h07);
    tickn(3); rd(2'd2, v); chk("R13 lo after ticks", v, 8'h04);
    wr(2'd3, 8'hA0); wr(2'd2, 8'h01); tickn(1);
    rd(2'd2, v); chk("R13 hi only", v, 8'h01);
    rd(2'd2, v); chk("R13 hi only again", v, 8'h01);

    // R6 square wave sweep on channel 0
    for (int n = 1; n <= 12; n++) begin
      wr(2'd3, 8'h36); chk("R2 square starts high", out[0], 1);
      wr(2'd0, 8'(n)); wr(2'd0, 8'h00);
      tickn(1); chk("R6 high after load", out[0], 1);
      for (int k = 1; k <= 3 * n; k++) begin
        tickn(1);
        chk($sformatf("R6 n=%0d k=%0d", n, k), out[0], ((n - (k % n)) > (n / 2)) ? 1 : 0);
      end
    end

    // R7 strobe on channel 1
    wr(2'd3, 8'h78); chk("R2 strobe starts high", out[1], 1);
    wr(2'd1, 8'h03); wr(2'd1, 8'h00);
    tickn(1); chk("R7 high after load", out[1], 1);
    tickn(2); chk("R7 high before zero", out[1], 1);
    tickn(1); chk("R7 low at zero", out[1], 0);
    tickn(1); chk("R7 high again", out[1], 1);
    tickn(5); chk("R7 stays high", out[1], 1);

    // R8 gate on channel 2
    gate[2] = 1'b0;
    wr(2'd3, 8'hB0); wr(2'd2, 8'h03); wr(2'd2, 8'h00);
    tickn(1); tickn(10);
    chk("R8 out frozen", out[2], 0);
    rd(2'd2, v); chk("R8 count frozen lo", v, 8'h03);
    rd(2'd2, v); chk("R8 count frozen hi", v, 8'h00);
    gate[2] = 1'b1;
    tickn(2); chk("R8 resumed before terminal", out[2], 0);
    tickn(1); chk("R8 resumed terminal", out[2], 1);

    // R11 multi-channel read-back, R2 running switch from square
    wr(2'd3, 8'h30); chk("R2 square to oneshot", out[0], 0);
    wr(2'd0, 8'h00); wr(2'd0, 8'h01);
    wr(2'd3, 8'h70); wr(2'd1, 8'h00); wr(2'd1, 8'h02);
    tickn(1); tickn(16);
    wr(2'd3, 8'hD6); tickn(7);
    rd(2'd0, v); chk("R11 ch0 lo", v, 8'hF0);
    rd(2'd0, v); chk("R11 ch0 hi", v, 8'h00);
    rd(2'd1, v); chk("R11 ch1 lo", v, 8'hF0);
    rd(2'd1, v); chk("R11 ch1 hi", v, 8'h01);
    wr(2'd3, 8'hC2);
    rd(2'd0, v); chk("R11 status first", v, 8'h30);
    rd(2'd0, v); chk("R11 count lo", v, 8'hE9);
    rd(2'd0, v); chk("R11 count hi", v, 8'h00);

    // R9 count of zero on channel 2
    wr(2'd3, 8'hB0); wr(2'd2, 8'h00); wr(2'd2, 8'h00);
    tickn(1); tickn(65535); chk("R9 not yet terminal", out[2], 0);
    tickn(1); chk("R9 terminal after 65536", out[2], 1);

    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    total++; bad++;
    $display("FAIL watchdog actual=running expected=done");
    $display("test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule